// File: doc/BRIEF.md
# Width-Expanded FIFO with Composite Flags

This block makes one wide FIFO out of several narrower FIFO slices. Every slice has the same depth, and all slices see the same write clock, read clock, write enable, read enable and reset. Slices may have different widths. Each slice stores its own bit range of the wide word, and the wide output word is the same concatenation. Slice 0 holds the least significant bits.

Each slice makes its own active-low status flags. These flags can leave their asserted state up to one clock apart from slice to slice, because the clock-domain synchronizers in the slices can differ in depth. The top level therefore builds composite flags that report data or space only once every slice agrees. The same composite flags gate the enables that go to the slices. As a result, no slice ever accepts or releases a word that another slice has not.

A mode parameter selects one of two modes. In standard mode, a read enable moves the next word into the registered output. In fall-through mode, the first word appears at the output without any read. The half-full indication is taken from slice 0 alone.

Top module: `wide_fifo`

## Requirements
- R1: The wide word is the concatenation of the slice buses, with slice 0 at bit 0 upward. Words come out in write order, and each output word is exactly one written word, never a mix of two.
- R2: In standard mode, `rd_flag_n` is low (empty) while any slice is empty. After a write into an empty FIFO it goes high S+1 read-clock edges after the write edge, where S is the largest synchronizer depth of any slice.
- R3: In standard mode, `wr_flag_n` is low (full) while any slice is full. The FIFO holds exactly 2^AW words, and a write enable given while full stores nothing.
- R4: In fall-through mode, `rd_flag_n` is low (output valid) only while every slice holds a valid output word. After a write into an empty FIFO it goes low S+2 read-clock edges after the write edge, with the word on `rdata` and no read needed.
- R5: In fall-through mode, `wr_flag_n` is low (ready) only while no slice is full. The FIFO holds exactly 2^AW+1 words.
- R6: In standard mode, a read enable given while `rd_flag_n` is low leaves `rdata` unchanged and moves no read pointer.
- R7: `half_n` is low while the write-side occupancy of slice 0 is at least 2^(AW-1) words, and high otherwise.
- R8: After reset, `rdata` is zero and `half_n` is high. In standard mode `rd_flag_n` is low and `wr_flag_n` is high. In fall-through mode `rd_flag_n` is high and `wr_flag_n` is low.
- R9: In standard mode, after one read from a full FIFO, `wr_flag_n` goes high S+1 write-clock edges after the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock shared by all slices |
| rclk | input | 1 | Read clock shared by all slices |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| wen | input | 1 | Write enable; it takes effect only while the composite write flag allows a write |
| wdata | input | TW (sum of slice widths) | Wide write word |
| ren | input | 1 | Read enable (standard mode) or pop (fall-through mode), gated by the composite read flag |
| rdata | output | TW | Wide registered read word |
| rd_flag_n | output | 1 | Composite empty flag (standard mode) or output-ready flag (fall-through mode), active low |
| wr_flag_n | output | 1 | Composite full flag (standard mode) or input-ready flag (fall-through mode), active low |
| half_n | output | 1 | Half-full flag from slice 0, active low |

## Verification
Both instances of the bench give one slice an extra synchronizer stage. The bench then samples the composite flags in the exact cycle in which the faster slices already agree but the slow slice does not. A design that took the flags from a single slice, or combined them with the wrong gate, would report data or space one cycle early and return a word with one field stale. The bench fills the fall-through instance while the fast and slow slices release space at different times. A design without write gating would let the fast slices take an extra word, and every later word would come back with its fields taken from two different writes. The bench also pushes a read into an empty standard FIFO and a write into a full one. A design without guards would show garbage or overwrite unread data.

// File: rtl/wfifo_pkg.sv
package wfifo_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;

  localparam int MAX_SLICES = 16;
  typedef int width_list_t [MAX_SLICES];

  // Sum of the first n slice widths: bit offset of slice n in the wide word.
  function automatic int sum_widths(width_list_t w, int n);
    int s;
    s = 0;
    for (int k = 0; k < n; k++) s += w[k];
    return s;
  endfunction
endpackage

// File: rtl/wf_sync.sv
module wf_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/wf_slice.sv
module wf_slice import wfifo_pkg::*; #(
  parameter int         W    = 8,
  parameter int         AW   = 3,
  parameter int         SYNC = 2,
  parameter fifo_mode_e MODE = MODE_STD
) (
  input  logic         wclk,
  input  logic         rclk,
  input  logic         rst,
  input  logic         wr_go,
  input  logic [W-1:0] wdat,
  input  logic         rd_go,
  output logic [W-1:0] rdat,
  output logic         rflag_n,
  output logic         wflag_n,
  output logic         half_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam logic [AW:0] HALF = PW'(DEPTH / 2);
  localparam logic [AW:0] ONE  = PW'(1);

  function automatic logic [AW:0] g2b(input logic [AW:0] g);
    logic [AW:0] b;
    b[AW] = g[AW];
    for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [W-1:0] mem [DEPTH];

  // write domain
  logic [AW:0] wbin, wgray, rq_gray, wbin_nxt, wgray_nxt, used_nxt;
  logic        full, half, full_nxt;
  // read domain
  logic [AW:0] rbin, rgray, wq_gray, rbin_nxt, rgray_nxt;
  logic        empty, empty_nxt, rd_mem;

  wf_sync #(.W(PW), .STAGES(SYNC)) u_rsync (
    .clk(wclk), .rst(rst), .d(rgray), .q(rq_gray)
  );
  wf_sync #(.W(PW), .STAGES(SYNC)) u_wsync (
    .clk(rclk), .rst(rst), .d(wgray), .q(wq_gray)
  );

  assign wbin_nxt  = wr_go ? wbin + ONE : wbin;
  assign wgray_nxt = (wbin_nxt >> 1) ^ wbin_nxt;
  assign full_nxt  = (wgray_nxt == {~rq_gray[AW:AW-1], rq_gray[AW-2:0]});
  assign used_nxt  = wbin_nxt - g2b(rq_gray);

  always_ff @(posedge wclk) begin
    if (rst) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      half  <= 1'b0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= wgray_nxt;
      full  <= full_nxt;
      half  <= (used_nxt >= HALF);
    end
  end

  // storage without reset so that a block RAM can be inferred
  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= wdat;
  end

  assign half_n = ~half;

  assign rbin_nxt  = rd_mem ? rbin + ONE : rbin;
  assign rgray_nxt = (rbin_nxt >> 1) ^ rbin_nxt;
  assign empty_nxt = (rgray_nxt == wq_gray);

  always_ff @(posedge rclk) begin
    if (rst) begin
      rbin  <= '0;
      rgray <= '0;
      empty <= 1'b1;
      rdat  <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= rgray_nxt;
      empty <= empty_nxt;
      if (rd_mem) rdat <= mem[rbin[AW-1:0]];
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
    wr_go |-> !full);  // R3

  if (MODE == MODE_FWFT) begin : g_fwft
    logic ov;
    assign rd_mem = (!ov || rd_go) && !empty;
    always_ff @(posedge rclk) begin
      if (rst)         ov <= 1'b0;
      else if (rd_mem) ov <= 1'b1;
      else if (rd_go)  ov <= 1'b0;
    end
    assign rflag_n = ~ov;
    assign wflag_n = full;

    AST_POP_ONLY_VALID: assert property (@(posedge rclk) disable iff (rst)
      rd_go |-> ov);  // R4
    AST_HOLD_HEAD_WORD: assert property (@(posedge rclk) disable iff (rst)
      (ov && !rd_go) |=> (ov && $stable(rdat)));  // R4
  end else begin : g_std
    assign rd_mem  = rd_go;
    assign rflag_n = ~empty;
    assign wflag_n = ~full;

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst)
      rd_go |-> !empty);  // R6
    AST_IDLE_HOLDS_DATA: assert property (@(posedge rclk) disable iff (rst)
      !rd_go |=> $stable(rdat));  // R6
  end
endmodule

// File: rtl/wide_fifo.sv
module wide_fifo import wfifo_pkg::*; #(
  parameter int          NS        = 3,
  parameter width_list_t SW        = '{8, 16, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0},
  parameter int          AW        = 3,
  parameter int          SYNC      = 2,
  parameter logic [NS-1:0] SKEW_MASK = '0,
  parameter fifo_mode_e  MODE      = MODE_STD,
  localparam int         TW        = sum_widths(SW, NS)
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst,
  input  logic          wen,
  input  logic [TW-1:0] wdata,
  input  logic          ren,
  output logic [TW-1:0] rdata,
  output logic          rd_flag_n,
  output logic          wr_flag_n,
  output logic          half_n
);
  logic [NS-1:0] rflag_vec, wflag_vec, half_vec;
  logic          rd_ok, wr_ok, rd_go, wr_go;

  for (genvar i = 0; i < NS; i++) begin : g_slice
    localparam int LO = sum_widths(SW, i);
    localparam int W  = SW[i];
    wf_slice #(
      .W(W), .AW(AW), .SYNC(SYNC + int'(SKEW_MASK[i])), .MODE(MODE)
    ) u_slice (
      .wclk    (wclk),
      .rclk    (rclk),
      .rst     (rst),
      .wr_go   (wr_go),
      .wdat    (wdata[LO +: W]),
      .rd_go   (rd_go),
      .rdat    (rdata[LO +: W]),
      .rflag_n (rflag_vec[i]),
      .wflag_n (wflag_vec[i]),
      .half_n  (half_vec[i])
    );
  end

  // Composite flags: report data or space only when every slice agrees.
  if (MODE == MODE_FWFT) begin : g_cmp_fwft
    assign rd_flag_n = |rflag_vec;
    assign wr_flag_n = |wflag_vec;
    assign rd_ok     = ~rd_flag_n;
    assign wr_ok     = ~wr_flag_n;
  end else begin : g_cmp_std
    assign rd_flag_n = &rflag_vec;
    assign wr_flag_n = &wflag_vec;
    assign rd_ok     = rd_flag_n;
    assign wr_ok     = wr_flag_n;
  end

  assign rd_go  = ren & rd_ok;
  assign wr_go  = wen & wr_ok;
  assign half_n = half_vec[0];

  if (NS > 1) begin : g_spare_half
    logic unused_half;
    assign unused_half = ^half_vec[NS-1:1];
  end
endmodule

// File: tb/test_wide_fifo.sv
module test_wide_fifo;
  import wfifo_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int TW    = 36;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic          s_wen = 1'b0, s_ren = 1'b0;
  logic [TW-1:0] s_wdata = '0, s_rdata;
  logic          s_rf, s_wf, s_half;
  logic          f_wen = 1'b0, f_ren = 1'b0;
  logic [TW-1:0] f_wdata = '0, f_rdata;
  logic          f_rf, f_wf, f_half;

  wide_fifo #(.SKEW_MASK(3'b010), .MODE(MODE_STD)) i_wide_fifo (
    .wclk(clk), .rclk(clk), .rst(rst), .wen(s_wen), .wdata(s_wdata),
    .ren(s_ren), .rdata(s_rdata), .rd_flag_n(s_rf), .wr_flag_n(s_wf),
    .half_n(s_half)
  );

  wide_fifo #(.SKEW_MASK(3'b010), .MODE(MODE_FWFT)) i_wide_fifo_ff (
    .wclk(clk), .rclk(clk), .rst(rst), .wen(f_wen), .wdata(f_wdata),
    .ren(f_ren), .rdata(f_rdata), .rd_flag_n(f_rf), .wr_flag_n(f_wf),
    .half_n(f_half)
  );

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  // {1 = write / 0 = read and expect, word}
  localparam logic [TW:0] VEC [10] = '{
    {1'b1, 36'h1A2B3C4D5}, {1'b1, 36'hF0E1D2C3B}, {1'b1, 36'h00FFFF000},
    {1'b0, 36'h1A2B3C4D5}, {1'b1, 36'hA5A5A5A5A}, {1'b0, 36'hF0E1D2C3B},
    {1'b0, 36'h00FFFF000}, {1'b0, 36'hA5A5A5A5A}, {1'b1, 36'h123456789},
    {1'b0, 36'h123456789}
  };

  task automatic chk(input bit ok, input string req, input logic [TW-1:0] act,
                     input logic [TW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic s_write(input logic [TW-1:0] d);
    int n = 0;
    while (s_wf !== 1'b1 && n < 40) begin @(negedge clk); n++; end
    if (n >= 40) chk(1'b0, "R3 write wait", TW'(s_wf), TW'(1));
    s_wen = 1'b1; s_wdata = d;
    @(negedge clk);
    s_wen = 1'b0;
  endtask

  task automatic s_read(input logic [TW-1:0] exp, input string req);
    int n = 0;
    while (s_rf !== 1'b1 && n < 40) begin @(negedge clk); n++; end
    if (n >= 40) chk(1'b0, "R2 read wait", TW'(s_rf), TW'(1));
    s_ren = 1'b1;
    @(negedge clk);
    s_ren = 1'b0;
    chk(s_rdata === exp, req, s_rdata, exp);
  endtask

  task automatic f_write(input logic [TW-1:0] d);
    int n = 0;
    while (f_wf !== 1'b0 && n < 40) begin @(negedge clk); n++; end
    if (n >= 40) chk(1'b0, "R5 write wait", TW'(f_wf), TW'(0));
    f_wen = 1'b1; f_wdata = d;
    @(negedge clk);
    f_wen = 1'b0;
  endtask

  task automatic f_read(input logic [TW-1:0] exp, input string req);
    int n = 0;
    while (f_rf !== 1'b0 && n < 40) begin @(negedge clk); n++; end
    if (n >= 40) chk(1'b0, "R4 read wait", TW'(f_rf), TW'(0));
    chk(f_rdata === exp, req, f_rdata, exp);
    f_ren = 1'b1;
    @(negedge clk);
    f_ren = 1'b0;
  endtask

  initial begin
    int cnt;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8 reset state
    chk(s_rdata === '0,  "R8 std rdata",  s_rdata, '0);
    chk(s_rf === 1'b0,   "R8 std empty",  TW'(s_rf), TW'(0));
    chk(s_wf === 1'b1,   "R8 std full",   TW'(s_wf), TW'(1));
    chk(s_half === 1'b1, "R8 std half",   TW'(s_half), TW'(1));
    chk(f_rdata === '0,  "R8 ff rdata",   f_rdata, '0);
    chk(f_rf === 1'b1,   "R8 ff ready",   TW'(f_rf), TW'(1));
    chk(f_wf === 1'b0,   "R8 ff input",   TW'(f_wf), TW'(0));

    // R2: slowest slice has 3 sync stages -> empty clears after edge 4
    s_wen = 1'b1; s_wdata = 36'hCAFE01234;
    @(negedge clk);            // write edge P0 passed
    s_wen = 1'b0;
    repeat (3) @(negedge clk); // after P3: fast slices ready, slow not
    chk(s_rf === 1'b0, "R2 composite still empty at S", TW'(s_rf), TW'(0));
    @(negedge clk);            // after P4
    chk(s_rf === 1'b1, "R2 composite ready at S+1", TW'(s_rf), TW'(1));
    s_read(36'hCAFE01234, "R1 first word");
    chk(s_rf === 1'b0, "R2 empty after last read", TW'(s_rf), TW'(0));

    // R6 read while empty is ignored
    s_ren = 1'b1;
    @(negedge clk);
    s_ren = 1'b0;
    chk(s_rdata === 36'hCAFE01234, "R6 rdata held", s_rdata, 36'hCAFE01234);
    chk(s_rf === 1'b0, "R6 still empty", TW'(s_rf), TW'(0));
    s_write(36'h0BEEF5678);
    s_read(36'h0BEEF5678, "R6 pointer not moved");

    // R4: fall-through output appears after S+2 edges
    f_wen = 1'b1; f_wdata = 36'hD00DF00D1;
    @(negedge clk);
    f_wen = 1'b0;
    repeat (4) @(negedge clk); // after P4: slow slice still invalid
    chk(f_rf === 1'b1, "R4 not ready at S+1", TW'(f_rf), TW'(1));
    @(negedge clk);            // after P5
    chk(f_rf === 1'b0, "R4 ready at S+2", TW'(f_rf), TW'(0));
    chk(f_rdata === 36'hD00DF00D1, "R4 word without read", f_rdata, 36'hD00DF00D1);
    f_ren = 1'b1;
    @(negedge clk);
    f_ren = 1'b0;
    chk(f_rf === 1'b1, "R4 not ready after pop", TW'(f_rf), TW'(1));

    // R1 vector table, both modes
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][TW]) begin
        s_write(VEC[i][TW-1:0]);
        f_write(VEC[i][TW-1:0]);
      end else begin
        s_read(VEC[i][TW-1:0], "R1 std order/word");
        f_read(VEC[i][TW-1:0], "R1 ff order/word");
      end
    end

    // R7 half flag on idle standard FIFO
    repeat (10) @(negedge clk);
    for (int i = 0; i < DEPTH / 2 - 1; i++) s_write(TW'(36'h100000000 + i));
    @(negedge clk);
    chk(s_half === 1'b1, "R7 below half", TW'(s_half), TW'(1));
    s_write(TW'(36'h100000000 + DEPTH / 2 - 1));
    chk(s_half === 1'b0, "R7 at half", TW'(s_half), TW'(0));

    // R3 fill to depth, extra write ignored
    for (int i = DEPTH / 2; i < DEPTH; i++) s_write(TW'(36'h100000000 + i));
    chk(s_wf === 1'b0, "R3 full at depth", TW'(s_wf), TW'(0));
    s_wen = 1'b1; s_wdata = 36'hBADBADBAD;
    repeat (2) @(negedge clk);
    s_wen = 1'b0;
    chk(s_wf === 1'b0, "R3 still full", TW'(s_wf), TW'(0));

    // R9 full release latency after one read
    s_ren = 1'b1;
    @(negedge clk);            // read edge P0
    s_ren = 1'b0;
    chk(s_rdata === 36'h100000000, "R1 oldest out", s_rdata, 36'h100000000);
    repeat (3) @(negedge clk);
    chk(s_wf === 1'b0, "R9 still full at S", TW'(s_wf), TW'(0));
    @(negedge clk);
    chk(s_wf === 1'b1, "R9 space at S+1", TW'(s_wf), TW'(1));
    for (int i = 1; i < DEPTH; i++) s_read(TW'(36'h100000000 + i), "R3 stored words");
    chk(s_rf === 1'b0, "R3 extra word not stored", TW'(s_rf), TW'(0));
    repeat (10) @(negedge clk);
    chk(s_half === 1'b1, "R7 back below half", TW'(s_half), TW'(1));

    // R5 fall-through capacity under slice skew
    repeat (10) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      if (f_wf === 1'b0) begin
        f_wen = 1'b1; f_wdata = TW'(36'h200000000 + cnt); cnt++;
      end else begin
        f_wen = 1'b0;
      end
      @(negedge clk);
    end
    f_wen = 1'b0;
    chk(cnt == DEPTH + 1, "R5 capacity", TW'(cnt), TW'(DEPTH + 1));
    chk(f_wf === 1'b1, "R5 not ready when full", TW'(f_wf), TW'(1));
    for (int i = 0; i < DEPTH + 1; i++) f_read(TW'(36'h200000000 + i), "R5 words intact");
    chk(f_rf === 1'b1, "R4 drained", TW'(f_rf), TW'(1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule